// File: doc/BRIEF.md
# Scoreboard Out-of-Order Issue Controller

This block is the central hazard tracker of a dynamically scheduled pipeline. Decoded instructions arrive in program order on a valid/ready handshake, each carrying an operation code, a destination register and two source registers. The controller assigns each instruction to one of five functional units: an integer/load unit, two multipliers, an adder/subtractor and a divider. After that it lets each unit fetch its operands, run and retire its result as soon as that unit's own hazards clear. Execution and completion can therefore run ahead of program order. Issue itself never does.

Each unit keeps a record of its destination, its sources, the unit that will produce each source, and whether each source can be read now. A per-register table names the unit that will write the register next. These structures stop issue on structural and write-after-write hazards, hold operand reads on read-after-write hazards, and hold write-back on write-after-read hazards. The execution stage of each unit is modelled as a fixed-latency countdown. The outputs are the issue handshake plus one operand-read grant and one write-back grant per unit. A grant is high in the cycle in which the unit reads from or writes to the register file. There is no forwarding: a value written in one cycle can be read in the next.

Top module: `sb_ctrl`

## Requirements
- R1: An instruction is accepted (`in_valid` and `in_ready` high at a clock edge) only when its unit is idle and no accepted, unretired instruction has the same destination. While the head instruction is held, no later instruction is accepted.
- R2: Unit selection by `in_op`: 0 load → integer unit (grant bit 0); 1 add and 2 subtract → adder (bit 3); 3 multiply → first multiplier (bit 1) if it is idle, otherwise the second (bit 2); 4 divide → divider (bit 4). Codes 5 to 7 are never accepted.
- R3: A unit whose sources are both ready gets its operand-read grant for exactly one cycle. The earliest such cycle is the one after the instruction is accepted.
- R4: A source that a unit in flight will write becomes readable in the cycle after that unit's write-back grant. This also holds when the consuming instruction is accepted in the producer's write-back cycle.
- R5: A unit with latency L that reads its operands in cycle C is ready to retire in cycle C+L+1. L is 1 for load, 2 for add/subtract, 10 for multiply and 40 for divide.
- R6: A ready unit is held from write-back while any other unit has an unread source equal to its destination, and that source is marked ready. It retires in the cycle after that read.
- R7: Units with different destinations that are ready in the same cycle all receive their write-back grants in that cycle.
- R8: The source fields of a load are ignored: a load reads its operands in the cycle after issue even if those registers are pending.
- R9: Synchronous active-low reset idles every unit and empties the register table. After reset no grant appears, and a new instruction is accepted in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_op | input | 3 | Operation code (see R2) |
| in_dst | input | RW | Destination register index |
| in_src1 | input | RW | First source register index |
| in_src2 | input | RW | Second source register index |
| rd_grant | output | 5 | Per-unit operand-read grant |
| wb_grant | output | 5 | Per-unit write-back grant |

## Verification
The bench uses the default parameters: 32 registers and latencies of 1, 2, 10 and 40 cycles. With these values a short program produces every hazard kind. This includes a divide held 12 cycles behind a multiply, and an add whose retirement waits for that divide's read. The bench predicts the issue, read and write-back cycle of every instruction from the requirements. It covers in-order stalls, the spill to the second multiplier, two units retiring together, a consumer accepted in its producer's write-back cycle, and a reset in the middle of execution.

// File: rtl/sb_pkg.sv
// Shared types of the scoreboard controller: unit identifiers, operation
// codes and the per-unit lifecycle phase.
package sb_pkg;
    localparam int NUM_FU = 5;

    typedef enum logic [2:0] {
        FU_INT  = 3'd0,
        FU_MUL1 = 3'd1,
        FU_MUL2 = 3'd2,
        FU_ADD  = 3'd3,
        FU_DIV  = 3'd4,
        FU_NONE = 3'd5
    } fu_id_t;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_MUL  = 3'd3,
        OP_DIV  = 3'd4
    } op_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_EXEC = 2'd2,
        PH_DONE = 2'd3
    } phase_t;
endpackage

// File: rtl/sb_issue_sel.sv
// Issue selector: maps the operation code to a functional unit and decides
// whether the head instruction may be accepted.
// Assumes: busy and pend_dst are registered state from the start of the cycle.
module sb_issue_sel
    import sb_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [NUM_FU-1:0] busy,
    input  fu_id_t            pend_dst,
    output fu_id_t            fu,
    output logic              ok
);
    logic [7:0] busy_pad;

    // Pick the target unit and check the structural and WAW conditions.
    always_comb begin
        busy_pad = 8'(busy);
        case (op)
            OP_LOAD:        fu = FU_INT;
            OP_ADD, OP_SUB: fu = FU_ADD;
            OP_MUL:         fu = busy[FU_MUL1] ? FU_MUL2 : FU_MUL1;
            OP_DIV:         fu = FU_DIV;
            default:        fu = FU_NONE;
        endcase
        ok = (fu != FU_NONE) && !busy_pad[fu] && (pend_dst == FU_NONE);
    end
endmodule

// File: rtl/sb_result_table.sv
// Register result table: one entry per register naming the unit that will
// write it next, or FU_NONE.
// Assumes: an issue never targets a register cleared in the same cycle
// (issue requires the registered entry to be empty).
module sb_result_table
    import sb_pkg::*;
#(
    parameter int REGS = 32,
    parameter int RW   = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_fire,
    input  logic [RW-1:0]     issue_dst,
    input  fu_id_t            issue_fu,
    input  logic [NUM_FU-1:0] wb_vec,
    input  logic [RW-1:0]     fi [NUM_FU],
    output fu_id_t            pend [REGS]
);
    // Clear entries of retiring units, then claim the new destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < REGS; r++) pend[r] <= FU_NONE;
        end else begin
            for (int u = 0; u < NUM_FU; u++)
                if (wb_vec[u]) pend[fi[u]] <= FU_NONE;
            if (issue_fire) pend[issue_dst] <= issue_fu;
        end
    end
endmodule

// File: rtl/sb_unit_slot.sv
// One functional-unit record: destination, sources, producer tags, ready
// flags and a fixed-latency execution countdown.
// Assumes: alloc only arrives while idle; war_hold comes from the other slots.
module sb_unit_slot
    import sb_pkg::*;
#(
    parameter int RW  = 5,
    parameter int CW  = 6,
    parameter int LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [RW-1:0]     a_dst,
    input  logic [RW-1:0]     a_src1,
    input  logic [RW-1:0]     a_src2,
    input  logic              a_use,
    input  fu_id_t            a_q1,
    input  fu_id_t            a_q2,
    input  logic              a_r1,
    input  logic              a_r2,
    input  logic [NUM_FU-1:0] wb_vec,
    input  logic              war_hold,
    output logic              busy,
    output logic [RW-1:0]     fi,
    output logic [RW-1:0]     fj,
    output logic [RW-1:0]     fk,
    output logic              uses,
    output logic              rj,
    output logic              rk,
    output logic              rd_grant,
    output logic              wb_grant
);
    phase_t        phase;
    fu_id_t        qj, qk;
    logic [CW-1:0] cnt;
    logic [7:0]    wb_pad;

    // Grants and wake-up lookups from the registered record.
    always_comb begin
        wb_pad   = 8'(wb_vec);
        busy     = (phase != PH_IDLE);
        rd_grant = (phase == PH_WAIT) && rj && rk;
        wb_grant = (phase == PH_DONE) && !war_hold;
    end

    // Lifecycle: fill at issue, wake on producer retire, count, retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            qj    <= FU_NONE;
            qk    <= FU_NONE;
            rj    <= 1'b0;
            rk    <= 1'b0;
            cnt   <= '0;
            fi    <= '0;
            fj    <= '0;
            fk    <= '0;
            uses  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (alloc) begin
                    phase <= PH_WAIT;
                    fi    <= a_dst;
                    fj    <= a_src1;
                    fk    <= a_src2;
                    uses  <= a_use;
                    qj    <= a_q1;
                    qk    <= a_q2;
                    rj    <= a_r1;
                    rk    <= a_r2;
                end
                PH_WAIT: if (rd_grant) begin
                    rj    <= 1'b0;
                    rk    <= 1'b0;
                    cnt   <= CW'(LAT - 1);
                    phase <= PH_EXEC;
                end else begin
                    if (qj != FU_NONE && wb_pad[qj]) begin
                        rj <= 1'b1;
                        qj <= FU_NONE;
                    end
                    if (qk != FU_NONE && wb_pad[qk]) begin
                        rk <= 1'b1;
                        qk <= FU_NONE;
                    end
                end
                PH_EXEC: if (cnt == '0) phase <= PH_DONE;
                         else           cnt   <= cnt - 1'b1;
                PH_DONE: if (wb_grant) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3: an operand read lasts exactly one cycle.
    a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |=> !rd_grant);

    // R5: retirement is preceded by the execution countdown, never by a read.
    a_r5_exec_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_grant) |-> !$past(rd_grant));
endmodule

// File: rtl/sb_ctrl.sv
// Scoreboard controller top: in-order issue into five functional-unit
// records, out-of-order operand read and write-back under RAW/WAR/WAW rules.
// Assumes: decisions use state registered at the start of each cycle; a
// consumer accepted in its producer's retire cycle sees the source as ready.
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int REGS     = 32,
    parameter int LAT_LOAD = 1,
    parameter int LAT_ADD  = 2,
    parameter int LAT_MUL  = 10,
    parameter int LAT_DIV  = 40,
    localparam int RW      = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_op,
    input  logic [RW-1:0]     in_dst,
    input  logic [RW-1:0]     in_src1,
    input  logic [RW-1:0]     in_src2,
    output logic [NUM_FU-1:0] rd_grant,
    output logic [NUM_FU-1:0] wb_grant
);
    localparam int LAT_M1  = (LAT_LOAD > LAT_ADD) ? LAT_LOAD : LAT_ADD;
    localparam int LAT_M2  = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
    localparam int LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
    localparam int CW      = $clog2(LAT_MAX + 1);

    fu_id_t            pend [REGS];
    fu_id_t            issue_fu, q1_raw, q2_raw, q1, q2;
    logic              issue_ok, issue_fire, use_src, r1, r2;
    logic [7:0]        wb_pad;
    logic [NUM_FU-1:0] busy, uses, rj, rk, war_hold;
    logic [RW-1:0]     fi [NUM_FU];
    logic [RW-1:0]     fj [NUM_FU];
    logic [RW-1:0]     fk [NUM_FU];

    sb_issue_sel u_sel (
        .op       (in_op),
        .busy     (busy),
        .pend_dst (pend[in_dst]),
        .fu       (issue_fu),
        .ok       (issue_ok)
    );

    // Handshake and producer tags, with wake-up from this cycle's retirements.
    always_comb begin
        in_ready   = issue_ok;
        issue_fire = in_valid && issue_ok;
        wb_pad     = 8'(wb_grant);
        use_src    = (in_op != OP_LOAD);
        q1_raw     = pend[in_src1];
        q2_raw     = pend[in_src2];
        r1 = !use_src || (q1_raw == FU_NONE) || wb_pad[q1_raw];
        r2 = !use_src || (q2_raw == FU_NONE) || wb_pad[q2_raw];
        q1 = r1 ? FU_NONE : q1_raw;
        q2 = r2 ? FU_NONE : q2_raw;
    end

    sb_result_table #(.REGS(REGS), .RW(RW)) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_fire (issue_fire),
        .issue_dst  (in_dst),
        .issue_fu   (issue_fu),
        .wb_vec     (wb_grant),
        .fi         (fi),
        .pend       (pend)
    );

    // WAR: hold a retiring unit while another slot still has to read its target.
    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            war_hold[u] = 1'b0;
            for (int f = 0; f < NUM_FU; f++)
                if (f != u && uses[f] &&
                    ((rj[f] && fj[f] == fi[u]) || (rk[f] && fk[f] == fi[u])))
                    war_hold[u] = 1'b1;
        end
    end

    for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
        localparam int LAT_U = (u == FU_INT) ? LAT_LOAD :
                               (u == FU_ADD) ? LAT_ADD  :
                               (u == FU_DIV) ? LAT_DIV  : LAT_MUL;
        sb_unit_slot #(.RW(RW), .CW(CW), .LAT(LAT_U)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (issue_fire && (issue_fu == fu_id_t'(u))),
            .a_dst    (in_dst),
            .a_src1   (in_src1),
            .a_src2   (in_src2),
            .a_use    (use_src),
            .a_q1     (q1),
            .a_q2     (q2),
            .a_r1     (r1),
            .a_r2     (r2),
            .wb_vec   (wb_grant),
            .war_hold (war_hold[u]),
            .busy     (busy[u]),
            .fi       (fi[u]),
            .fj       (fj[u]),
            .fk       (fk[u]),
            .uses     (uses[u]),
            .rj       (rj[u]),
            .rk       (rk[u]),
            .rd_grant (rd_grant[u]),
            .wb_grant (wb_grant[u])
        );

        // R9: a retired unit is idle in the following cycle.
        a_r9_free_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[u] |=> !busy[u]);

        for (genvar f = 0; f < NUM_FU; f++) begin : g_pair
            if (f != u) begin : g_chk
                // R6: no retirement over a register another unit must still read.
                a_r6_no_war_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
                    (uses[f] && rj[f] && fj[f] == fi[u]) |-> !wb_grant[u]);
            end
        end
    end

    // R1: an accepted destination is claimed by the chosen unit next cycle.
    a_r1_dest_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |=> pend[$past(in_dst)] == $past(issue_fu));

    // R2: only the five defined operation codes are ever accepted.
    a_r2_known_op: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |-> in_op <= 3'd4);
endmodule

// File: tb/sim_sb_ctrl.sv
module sim_sb_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MAXI = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] in_op = 3'd0;
    logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [4:0] rd_grant, wb_grant;

    int errors = 0;
    int checks = 0;

    int p_op [MAXI], p_dst [MAXI], p_s1 [MAXI], p_s2 [MAXI], p_fu [MAXI];
    int e_iss [MAXI], e_rd [MAXI], e_wb [MAXI];
    int g_iss [MAXI], g_rd [MAXI], g_wb [MAXI];

    sb_ctrl u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_op    (in_op),
        .in_dst   (in_dst),
        .in_src1  (in_src1),
        .in_src2  (in_src2),
        .rd_grant (rd_grant),
        .wb_grant (wb_grant)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put(input int i, input int op, input int d, input int s1, input int s2,
                       input int fu, input int iss, input int rd, input int wb);
        p_op[i] = op; p_dst[i] = d; p_s1[i] = s1; p_s2[i] = s2; p_fu[i] = fu;
        e_iss[i] = iss; e_rd[i] = rd; e_wb[i] = wb;
    endtask

    // Runs n queued instructions from reset; cycle 1 is the first cycle after reset.
    task automatic run_prog(input int n, input string t_iss, input string t_rd, input string t_wb);
        int owner [5];
        int idx = 0;
        int c = 0;
        bit acc;
        for (int i = 0; i < MAXI; i++) begin g_iss[i] = -1; g_rd[i] = -1; g_wb[i] = -1; end
        for (int u = 0; u < 5; u++) owner[u] = -1;
        do_reset();
        while (c < 150) begin
            c++;
            in_valid = (idx < n);
            if (idx < n) begin
                in_op = 3'(p_op[idx]); in_dst = 5'(p_dst[idx]);
                in_src1 = 5'(p_s1[idx]); in_src2 = 5'(p_s2[idx]);
            end
            #1;
            for (int u = 0; u < 5; u++) begin
                if (rd_grant[u] && owner[u] >= 0) g_rd[owner[u]] = c;
                if (wb_grant[u] && owner[u] >= 0) g_wb[owner[u]] = c;
            end
            acc = in_valid && in_ready;
            if (acc) begin
                g_iss[idx] = c;
                owner[p_fu[idx]] = idx;
            end
            @(negedge clk);
            if (acc) idx++;
            if (n > 0 && g_wb[n-1] >= 0 && idx == n) begin
                bit all = 1;
                for (int i = 0; i < n; i++) if (g_wb[i] < 0) all = 0;
                if (all) break;
            end
        end
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            chk(t_iss, $sformatf("instr %0d issue cycle", i), g_iss[i], e_iss[i]);
            chk(t_rd,  $sformatf("instr %0d read cycle", i),  g_rd[i],  e_rd[i]);
            chk(t_wb,  $sformatf("instr %0d write cycle", i), g_wb[i],  e_wb[i]);
        end
    endtask

    // R9: reset state, and reset in the middle of a multiply.
    task automatic t_reset();
        int seen = 0;
        do_reset();
        in_op = 3'd3; in_dst = 5'd0; in_src1 = 5'd1; in_src2 = 5'd2;
        #1;
        chk("R9", "rd_grant after reset", int'(rd_grant), 0);
        chk("R9", "wb_grant after reset", int'(wb_grant), 0);
        chk("R9", "ready after reset", int'(in_ready), 1);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9", "ready for same dest after mid-run reset", int'(in_ready), 1);
        for (int k = 0; k < 15; k++) begin
            if (rd_grant != 0 || wb_grant != 0) seen++;
            @(negedge clk);
            #1;
        end
        chk("R9", "grants after mid-run reset", seen, 0);
        // R2: undefined code is never accepted
        in_op = 3'd6; in_dst = 5'd3;
        #1;
        chk("R2", "ready for op code 6", int'(in_ready), 0);
    endtask

    // R1 R4 R6: dependent sequence with an in-order stall and a WAR hold.
    task automatic t_classic();
        put(0, 0, 6, 2, 2, 0, 1, 2, 4);
        put(1, 0, 2, 3, 3, 0, 5, 6, 8);
        put(2, 3, 0, 2, 4, 1, 6, 9, 20);
        put(3, 2, 8, 6, 2, 3, 7, 9, 12);
        put(4, 4, 10, 0, 6, 4, 8, 21, 62);
        put(5, 1, 6, 8, 2, 3, 13, 14, 22);
        run_prog(6, "R1", "R4", "R6");
    endtask

    // R1 R3 R5: WAW stall holds the next independent instruction too.
    task automatic t_waw();
        put(0, 1, 4, 1, 3, 3, 1, 2, 5);
        put(1, 3, 4, 5, 7, 1, 6, 7, 18);
        put(2, 0, 9, 0, 0, 0, 7, 8, 10);
        run_prog(3, "R1", "R3", "R5");
    endtask

    // R2 R3 R7: second multiplier, structural stall, simultaneous retirement.
    task automatic t_units();
        put(0, 3, 1, 2, 3, 1, 1, 2, 13);
        put(1, 3, 5, 6, 7, 2, 2, 3, 14);
        put(2, 3, 7, 8, 9, 1, 14, 15, 26);
        put(3, 1, 10, 12, 13, 3, 15, 16, 19);
        put(4, 0, 11, 0, 0, 0, 16, 17, 19);
        run_prog(5, "R2", "R3", "R7");
    endtask

    // R8 R4 R5: consumer accepted in producer retire cycle; load ignores pending sources.
    task automatic t_bypass();
        put(0, 0, 2, 0, 0, 0, 1, 2, 4);
        put(1, 3, 0, 4, 6, 1, 2, 3, 14);
        put(2, 3, 10, 12, 14, 2, 3, 4, 15);
        put(3, 4, 16, 2, 18, 4, 4, 5, 46);
        put(4, 0, 20, 16, 16, 0, 5, 6, 8);
        run_prog(5, "R8", "R4", "R5");
    endtask

    initial begin
        t_reset();
        t_classic();
        t_waw();
        t_units();
        t_bypass();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule